// File: doc/BRIEF.md
# NOR-Gate Ripple-Carry Adder

This block adds two unsigned or two's-complement words and a carry bit. The datapath has no behavioural operators. Every gate is an instance of a single 3-input NOR cell, and each cell has a one-nanosecond propagation delay. An inverter is the same cell with two inputs tied to zero. A wider NOR is put together from several of these cells.

Each bit stage receives its operand bits and the incoming carry in complemented form. It passes a complemented carry on to the next stage, so the true carry never travels along the chain. The true carry is made by an inverter only where it is needed: inside each stage for the sum bit, and at the most significant end for the carry-out port and the overflow flag.

The sum bit of each stage is built as a NOR of four maxterm NORs. Because the settling time is modelled at gate level, a user can rely on a fixed worst-case delay of 2N+4 ns from the last input change to final outputs.

Top module: `nor_ripple_adder`

## Requirements
- R1: Once the inputs have settled, `sum` equals the low N bits of `op_a + op_b + carry_in`.
- R2: `carry_out` is active-high and equals bit N of `op_a + op_b + carry_in`. `carry_in` is also active-high, so `carry_in=1` with both operands 0 gives `sum=1`.
- R3: The internal ripple net `carry_n[i]` holds the complement of the carry into bit i. `carry_n[0]` is the complement of `carry_in`, and `carry_n[N]` is the complement of the carry out of the top bit. The true carry into bit i is observable at the ports as `sum[i] ^ op_a[i] ^ op_b[i]`.
- R4: `overflow` is 1 exactly when `op_a[N-1]` equals `op_b[N-1]` and `sum[N-1]` differs from them. This is the same as the carry into the top bit differing from the carry out of it.
- R5: Every output reaches its final value no later than 2N+4 ns after the most recent input change, and then holds that value until the next input change.
- R6: Wrap corners. All ones plus `carry_in=1` gives `sum=0`, `carry_out=1` and `overflow=0`. Two operands of only the sign bit give `sum=0`, `carry_out=1` and `overflow=1`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | N | First operand |
| op_b | input | N | Second operand |
| carry_in | input | 1 | Carry into bit 0, active-high |
| sum | output | N | Sum word |
| carry_out | output | 1 | Carry out of bit N-1, active-high |
| overflow | output | 1 | Two's-complement overflow flag |

## Verification
The bound checker acts each time the inputs change after a vector has been held longer than the settling bound. For that settled vector it checks the sum and carry-out, the overflow rule and every complemented ripple net. It also flags any output movement that comes later than 2N+4 ns after an input change.

Only the bench's scenarios can show the following:
- the exhaustive 4-bit sweep;
- the wrap corners;
- that the final vector of a run is correct and stays stable at the bound.

The bench also reconstructs the true carries at the ports.

// File: rtl/nor_adder_pkg.sv
`timescale 1ns/1ps
package nor_adder_pkg;
    parameter int unsigned NOR_DELAY = 1;

    function automatic int unsigned settle_depth(input int unsigned width);
        return 2 * width + 4;
    endfunction
endpackage

// File: rtl/nor_cell3.sv
`timescale 1ns/1ps
module nor_cell3 (
    input  logic in_a,
    input  logic in_b,
    input  logic in_c,
    output logic out_y
);
    // The single logic primitive of the datapath: unit-delay 3-input NOR.
    assign #(nor_adder_pkg::NOR_DELAY) out_y = ~(in_a | in_b | in_c);
endmodule

// File: rtl/nor_cell4.sv
`timescale 1ns/1ps
module nor_cell4 (
    input  logic fast_0,
    input  logic fast_1,
    input  logic slow_0,
    input  logic slow_1,
    output logic out_y
);
    // fast_* inputs pass through one level; slow_* inputs pass through three.
    logic pair_nor;
    logic pair_or;

    nor_cell3 u_pair (.in_a(slow_0),   .in_b(slow_1), .in_c(1'b0), .out_y(pair_nor));
    nor_cell3 u_inv  (.in_a(pair_nor), .in_b(1'b0),   .in_c(1'b0), .out_y(pair_or));
    nor_cell3 u_fin  (.in_a(fast_0),   .in_b(fast_1), .in_c(pair_or), .out_y(out_y));
endmodule

// File: rtl/nor_adder_stage.sv
`timescale 1ns/1ps
module nor_adder_stage (
    input  logic bit_x,
    input  logic bit_y,
    input  logic cy_n_in,
    output logic sum_bit,
    output logic cy_n_out
);
    logic x_n, y_n, cy_t;
    logic k_xy, k_xc, k_yc;
    logic m_000, m_011, m_101, m_110;

    // Local polarity recovery.
    nor_cell3 u_xn (.in_a(bit_x),   .in_b(1'b0), .in_c(1'b0), .out_y(x_n));
    nor_cell3 u_yn (.in_a(bit_y),   .in_b(1'b0), .in_c(1'b0), .out_y(y_n));
    nor_cell3 u_ct (.in_a(cy_n_in), .in_b(1'b0), .in_c(1'b0), .out_y(cy_t));

    // Complemented carry from complemented inputs only: two levels per stage.
    nor_cell3 u_kxy (.in_a(x_n),  .in_b(y_n),     .in_c(1'b0), .out_y(k_xy));
    nor_cell3 u_kxc (.in_a(x_n),  .in_b(cy_n_in), .in_c(1'b0), .out_y(k_xc));
    nor_cell3 u_kyc (.in_a(y_n),  .in_b(cy_n_in), .in_c(1'b0), .out_y(k_yc));
    nor_cell3 u_co  (.in_a(k_xy), .in_b(k_xc),    .in_c(k_yc), .out_y(cy_n_out));

    // Each term is 1 only on one even-parity input row.
    nor_cell3 u_m000 (.in_a(bit_x), .in_b(bit_y), .in_c(cy_t),    .out_y(m_000));
    nor_cell3 u_m011 (.in_a(bit_x), .in_b(y_n),   .in_c(cy_n_in), .out_y(m_011));
    nor_cell3 u_m101 (.in_a(x_n),   .in_b(bit_y), .in_c(cy_n_in), .out_y(m_101));
    nor_cell3 u_m110 (.in_a(x_n),   .in_b(y_n),   .in_c(cy_t),    .out_y(m_110));

    // Early terms (complemented carry) take the deep path.
    nor_cell4 u_sum (
        .fast_0(m_000), .fast_1(m_110),
        .slow_0(m_011), .slow_1(m_101),
        .out_y(sum_bit)
    );
endmodule

// File: rtl/nor_ovf_detect.sv
`timescale 1ns/1ps
module nor_ovf_detect (
    input  logic msb_cy_n_in,
    input  logic msb_cy_n_out,
    input  logic msb_cy_out,
    output logic ovf
);
    logic msb_cy_in, both_low, both_high;

    nor_cell3 u_ci  (.in_a(msb_cy_n_in), .in_b(1'b0),         .in_c(1'b0), .out_y(msb_cy_in));
    nor_cell3 u_lo  (.in_a(msb_cy_in),   .in_b(msb_cy_out),   .in_c(1'b0), .out_y(both_low));
    nor_cell3 u_hi  (.in_a(msb_cy_n_in), .in_b(msb_cy_n_out), .in_c(1'b0), .out_y(both_high));
    nor_cell3 u_fin (.in_a(both_low),    .in_b(both_high),    .in_c(1'b0), .out_y(ovf));
endmodule

// File: rtl/nor_ripple_adder.sv
`timescale 1ns/1ps
module nor_ripple_adder #(
    parameter int unsigned N = 8
) (
    input  logic [N-1:0] op_a,
    input  logic [N-1:0] op_b,
    input  logic         carry_in,
    output logic [N-1:0] sum,
    output logic         carry_out,
    output logic         overflow
);
    localparam int unsigned MSB = N - 1;

    logic [N:0] carry_n;
    logic       cy_top;

    nor_cell3 u_cin_n (.in_a(carry_in), .in_b(1'b0), .in_c(1'b0), .out_y(carry_n[0]));

    for (genvar i = 0; i < N; i++) begin : g_stage
        nor_adder_stage u_stage (
            .bit_x   (op_a[i]),
            .bit_y   (op_b[i]),
            .cy_n_in (carry_n[i]),
            .sum_bit (sum[i]),
            .cy_n_out(carry_n[i+1])
        );
    end

    nor_cell3 u_cout (.in_a(carry_n[N]), .in_b(1'b0), .in_c(1'b0), .out_y(cy_top));
    assign carry_out = cy_top;

    nor_ovf_detect u_ovf (
        .msb_cy_n_in (carry_n[MSB]),
        .msb_cy_n_out(carry_n[N]),
        .msb_cy_out  (cy_top),
        .ovf         (overflow)
    );
endmodule

// File: rtl/nor_adder_chk.sv
`timescale 1ns/1ps
module nor_adder_chk #(
    parameter int unsigned N = 8
) (
    input logic [N-1:0] op_a,
    input logic [N-1:0] op_b,
    input logic         carry_in,
    input logic [N-1:0] sum,
    input logic         carry_out,
    input logic         overflow,
    input logic [N:0]   carry_n
);
    localparam int unsigned DEPTH = nor_adder_pkg::settle_depth(N);

    time          t_in = 0;
    logic [N-1:0] held_a = '0;
    logic [N-1:0] held_b = '0;
    logic         held_c = 1'b0;
    logic [N:0]   exp_total;
    logic [N:0]   exp_cy;

    // On each input change, judge the vector that was held beyond the bound.
    always @(op_a or op_b or carry_in) begin
        if (($time - t_in) > DEPTH) begin
            exp_total = {1'b0, held_a} + {1'b0, held_b} + {{N{1'b0}}, held_c};
            exp_cy[0] = held_c;
            for (int i = 0; i < N; i++) begin
                exp_cy[i+1] = (held_a[i] & held_b[i]) | (held_a[i] & exp_cy[i]) |
                              (held_b[i] & exp_cy[i]);
            end
            assert_sum_R1: assert ({carry_out, sum} == exp_total)
                else $error("R1/R2 sum %0h expected %0h", {carry_out, sum}, exp_total);
            assert_ovf_R4: assert (overflow == ((held_a[N-1] == held_b[N-1]) &&
                                                (exp_total[N-1] != held_a[N-1])))
                else $error("R4 overflow %0b", overflow);
            assert_chain_R3: assert (carry_n == ~exp_cy)
                else $error("R3 chain %0h expected %0h", carry_n, ~exp_cy);
        end
        t_in   = $time;
        held_a = op_a;
        held_b = op_b;
        held_c = carry_in;
    end

    always @(sum or carry_out or overflow) begin
        assert_settle_R5: assert (($time - t_in) <= DEPTH)
            else $error("R5 output moved %0t after input change", $time - t_in);
    end
endmodule

bind nor_ripple_adder nor_adder_chk #(.N(N)) u_chk (
    .op_a(op_a), .op_b(op_b), .carry_in(carry_in),
    .sum(sum), .carry_out(carry_out), .overflow(overflow),
    .carry_n(carry_n)
);

// File: tb/tb_nor_ripple_adder.sv
`timescale 1ns/1ps
module tb_nor_ripple_adder;
    localparam int unsigned W8 = 8;
    localparam int unsigned W4 = 4;
    localparam int unsigned HOLD = nor_adder_pkg::settle_depth(W8) + 1;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic [W8-1:0] a8 = '0, b8 = '0, s8;
    logic          c8 = 1'b0, co8, ov8;
    logic [W4-1:0] a4 = '0, b4 = '0, s4;
    logic          c4 = 1'b0, co4, ov4;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;
    int unsigned exp_q[$];

    nor_ripple_adder #(.N(W8)) dut (
        .op_a(a8), .op_b(b8), .carry_in(c8),
        .sum(s8), .carry_out(co8), .overflow(ov8)
    );

    nor_ripple_adder #(.N(W4)) dut4 (
        .op_a(a4), .op_b(b4), .carry_in(c4),
        .sum(s4), .carry_out(co4), .overflow(ov4)
    );

    task automatic chk(input string req, input string what, input logic [15:0] act,
                       input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Drive both adders, wait past the bound, compare with the queued reference.
    task automatic apply(input logic [W8-1:0] x8, input logic [W8-1:0] y8, input logic z8,
                         input logic [W4-1:0] x4, input logic [W4-1:0] y4, input logic z4);
        int unsigned e8, e4;
        @(negedge clk);
        a8 = x8; b8 = y8; c8 = z8;
        a4 = x4; b4 = y4; c4 = z4;
        exp_q.push_back(int'(x8) + int'(y8) + int'(z8));
        exp_q.push_back(int'(x4) + int'(y4) + int'(z4));
        #(HOLD);
        e8 = exp_q.pop_front();
        e4 = exp_q.pop_front();
        chk("R1", "sum8", 16'(s8), 16'(e8 % 256));
        chk("R2", "cout8", 16'(co8), 16'(e8 / 256));
        chk("R3", "carries8", 16'(s8 ^ x8 ^ y8), 16'((e8 ^ x8 ^ y8) % 256));
        chk("R4", "ovf8", 16'(ov8), 16'((x8[7] == y8[7]) && (((e8 >> 7) & 1) != x8[7])));
        chk("R1", "sum4", 16'(s4), 16'(e4 % 16));
        chk("R2", "cout4", 16'(co4), 16'(e4 / 16));
        chk("R3", "carries4", 16'(s4 ^ x4 ^ y4), 16'((e4 ^ x4 ^ y4) % 16));
        chk("R4", "ovf4", 16'(ov4), 16'((x4[3] == y4[3]) && (((e4 >> 3) & 1) != x4[3])));
    endtask

    initial begin
        logic [W8-1:0] hold_s;
        // Zero operands: the settled state after start-up.
        apply('0, '0, 1'b0, '0, '0, 1'b0);
        // R2: active-high carry-in adds one.
        apply('0, '0, 1'b1, '0, '0, 1'b1);
        chk("R2", "cin adds one", 16'(s8), 16'd1);
        // R5: full-length ripple is final at the bound and stays put.
        apply(8'hFF, 8'h00, 1'b0, 4'h0, 4'h0, 1'b0);
        apply(8'hFF, 8'h00, 1'b1, 4'hF, 4'h0, 1'b1);
        chk("R5", "ripple sum at bound", 16'(s8), 16'h00);
        hold_s = s8;
        #3;
        chk("R5", "sum stays after bound", 16'(s8), 16'(hold_s));
        chk("R5", "cout stays after bound", 16'(co8), 16'd1);
        // R6: wrap corners.
        apply(8'hFF, 8'hFF, 1'b1, 4'hF, 4'hF, 1'b1);
        chk("R6", "all ones wrap sum", 16'(s8), 16'hFF);
        apply(8'hFF, 8'h00, 1'b1, 4'hF, 4'h0, 1'b1);
        chk("R6", "wrap zero sum", 16'(s8), 16'h00);
        chk("R6", "wrap zero ovf", 16'(ov8), 16'd0);
        apply(8'h80, 8'h80, 1'b0, 4'h8, 4'h8, 1'b0);
        chk("R6", "sign pair ovf", 16'(ov8), 16'd1);
        chk("R6", "sign pair cout", 16'(co4), 16'd1);
        apply(8'h7F, 8'h00, 1'b1, 4'h7, 4'h0, 1'b1);
        chk("R4", "positive overflow", 16'(ov8), 16'd1);
        // Exhaustive 4-bit sweep alongside random 8-bit vectors.
        for (int i = 0; i < 512; i++) begin
            apply(8'($urandom), 8'($urandom), 1'($urandom),
                  4'(i >> 5), 4'(i >> 1), 1'(i));
        end
        for (int i = 0; i < 300; i++) begin
            apply(8'($urandom), 8'($urandom), 1'($urandom),
                  4'($urandom), 4'($urandom), 1'($urandom));
        end
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R5 watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule